// File: doc/BRIEF.md
# Timer Interrupt Edge-to-Pending Converter

Each core has a private timer and a private watchdog, and each drives a level interrupt line. This block turns a low-to-high transition on any of those lines into one request to mark a private interrupt pending in the interrupt controller. Every request names the core it targets and the interrupt number to set. The lines are numbered so that a core's timer line is `2n` and its watchdog line is `2n+1`. A request therefore goes to core `index >> 1` and carries interrupt number 29 for a timer line or 30 for a watchdog line.

The block registers the previous level of every line on every clock. Rising edges set bits in a pending bitmap. The bitmap is drained through one valid/ready port. The lowest-numbered pending line is always presented first, and its bit clears when the port completes a handshake. A line that rises again while its request is still waiting does not make a second request. Reset clears the level history and the bitmap, so a line that is high when reset ends counts as a rising edge on the first clock after reset.

Top module: `tmr_irq_edge_req`

## Requirements
- R1: Input bit `2n` of `lvl_i` is core `n`'s timer line and bit `2n+1` is core `n`'s watchdog line. Only `2*NUM_CORES` lines exist.
- R2: A low-to-high change on a line, sampled at a clock edge, makes `req_valid_o` high right after that edge, for exactly one request on that line.
- R3: A line that stays high, stays low or falls produces no request.
- R4: `req_core_o` equals the index of the presented line shifted right by one.
- R5: `req_id_o` equals 29 plus bit 0 of the presented line's index: 29 for a timer line, 30 for a watchdog line.
- R6: Edges that arrive in the same cycle are all kept. They are presented one per completed handshake, lowest line index first.
- R7: A new rising edge on a line whose request is still waiting merges into that request. No second request follows.
- R8: A request is complete only in a cycle where `req_valid_o` and `req_ready_i` are both high. While `req_ready_i` is low, `req_valid_o` stays high.
- R9: While `rst_n` is low, `req_valid_o` is low. A line that is high on the first clock after reset counts as a rising edge.
- R10: The stored previous level follows the input on every clock, whether or not a request is waiting. A line that is still high after its request completes produces nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_i | input | 2*NUM_CORES | Level interrupt lines: even bits are timers, odd bits are watchdogs |
| req_ready_i | input | 1 | The interrupt controller accepts the presented request |
| req_valid_o | output | 1 | A set-pending request is presented |
| req_core_o | output | CORE_W | Target core of the presented request |
| req_id_o | output | ID_W | Private interrupt number to set pending |

## Verification
A corrupted level history shows one clock after the bad sample. It appears either as a request when the input did not change or as a lost request when a line rose. A pending bit that fails to clear shows at the port as the same core and number presented again right after a handshake. A bit that fails to set shows as a line that is skipped when several lines rise together. A wrong index encoding shows at once in `req_core_o` or `req_id_o` on the first request, so the bench walks every line and checks its core and number.

// File: rtl/tie_pkg.sv
package tie_pkg;
    // Private interrupt number used for a timer line; a watchdog line uses the next one.
    localparam int unsigned TIMER_IRQ_ID = 29;
    localparam int unsigned IRQ_ID_W     = 5;
endpackage

// File: rtl/tie_edge_det.sv
module tie_edge_det #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // The history follows the input on every clock, even when a request is waiting.
        st_d.prev = lvl_i;
        rise_o    = lvl_i & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tie_pend_map.sv
module tie_pend_map #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // A new edge wins over a clear of the same bit; an edge on a waiting bit merges.
        st_d.pend = (st_q.pend & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/tie_lsb_pick.sv
module tie_lsb_pick #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o   = |req_i;
        // Two's-complement trick isolates the lowest set bit.
        grant_o = req_i & (~req_i + N'(1));
        idx_o   = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
        end
    end
endmodule

// File: rtl/tmr_irq_edge_req.sv
module tmr_irq_edge_req
    import tie_pkg::*;
#(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned NLINES    = 2 * NUM_CORES,
    parameter int unsigned CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    parameter int unsigned ID_W      = IRQ_ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lvl_i,
    input  logic              req_ready_i,
    output logic              req_valid_o,
    output logic [CORE_W-1:0] req_core_o,
    output logic [ID_W-1:0]   req_id_o
);
    localparam int unsigned IDX_W = $clog2(NLINES);

    logic [NLINES-1:0] rise;
    logic [NLINES-1:0] pend;
    logic [NLINES-1:0] grant;
    logic [NLINES-1:0] clr;
    logic [IDX_W-1:0]  idx;
    logic              any;

    tie_edge_det #(.N(NLINES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl_i),
        .rise_o (rise)
    );

    tie_pend_map #(.N(NLINES)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (rise),
        .clr_i  (clr),
        .pend_o (pend)
    );

    tie_lsb_pick #(.N(NLINES), .IDX_W(IDX_W)) u_pick (
        .req_i   (pend),
        .any_o   (any),
        .grant_o (grant),
        .idx_o   (idx)
    );

    always_comb begin
        req_valid_o = any;
        clr         = grant & {NLINES{any & req_ready_i}};
        req_core_o  = CORE_W'(idx >> 1);
        req_id_o    = ID_W'(TIMER_IRQ_ID) + ID_W'(idx[0]);
    end
endmodule

// File: rtl/tie_chk.sv
module tie_chk #(
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned NLINES    = 2 * NUM_CORES,
    parameter int unsigned CORE_W    = 2,
    parameter int unsigned ID_W      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NLINES-1:0] lvl_i,
    input logic              req_ready_i,
    input logic              req_valid_o,
    input logic [CORE_W-1:0] req_core_o,
    input logic [ID_W-1:0]   req_id_o
);
    p_rise_gives_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lvl_i & ~$past(lvl_i))) |=> req_valid_o);

    p_quiet_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !req_valid_o && lvl_i == $past(lvl_i)) |=> !req_valid_o);

    p_core_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (int'(req_core_o) < int'(NUM_CORES)));

    p_id_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_id_o == ID_W'(29) || req_id_o == ID_W'(30)));

    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> req_valid_o);

    always_comb begin
        if (!rst_n) a_reset_idle_r9: assert (!req_valid_o);
    end
endmodule

bind tmr_irq_edge_req tie_chk #(
    .NUM_CORES (NUM_CORES),
    .NLINES    (NLINES),
    .CORE_W    (CORE_W),
    .ID_W      (ID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lvl_i       (lvl_i),
    .req_ready_i (req_ready_i),
    .req_valid_o (req_valid_o),
    .req_core_o  (req_core_o),
    .req_id_o    (req_id_o)
);

// File: tb/sim_tmr_irq_edge_req.sv
module sim_tmr_irq_edge_req;
    localparam int NC = 4;
    localparam int NL = 2 * NC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] lvl = '0;
    logic          ready = 1'b0;
    logic          valid;
    logic [1:0]    core;
    logic [4:0]    id;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tmr_irq_edge_req #(.NUM_CORES(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .req_ready_i(ready),
        .req_valid_o(valid), .req_core_o(core), .req_id_o(id)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expected: line k -> core k>>1, number 29 + k[0].
    task automatic expect_line(string tag, int line);
        checks++;
        if (valid !== 1'b1 || int'(core) != line / 2 || int'(id) != 29 + line % 2) begin
            errors++;
            $display("FAIL %s: got valid=%0b core=%0d id=%0d, expected valid=1 core=%0d id=%0d",
                     tag, valid, core, id, line / 2, 29 + line % 2);
        end
    endtask

    task automatic expect_idle(string tag);
        checks++;
        if (valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: got valid=%0b, expected valid=0", tag, valid);
        end
    endtask

    task automatic t_reset();
        rst_n = 0; lvl = '0; ready = 0;
        tick(); tick();
        expect_idle("R9 idle in reset");
        lvl = 8'h08;
        tick();
        expect_idle("R9 idle in reset with line high");
        rst_n = 1;
        tick();
        expect_line("R9 high at reset exit counts as edge", 3);
        ready = 1;
        tick();
        expect_idle("R10 line still high after accept");
        lvl = '0;
        tick();
        expect_idle("R3 falling line gives nothing");
    endtask

    task automatic t_each_line();
        ready = 1;
        for (int k = 0; k < NL; k++) begin
            lvl = NL'(1) << k;
            tick();
            expect_line("R1 R4 R5 line mapping", k);
            tick();
            expect_idle("R2 single request per edge");
            lvl = '0;
            tick();
            expect_idle("R3 fall is silent");
        end
    endtask

    task automatic t_multi();
        ready = 0;
        lvl = 8'b1010_0100;
        tick();
        expect_line("R6 lowest first", 2);
        tick();
        expect_line("R8 held while stalled", 2);
        ready = 1;
        tick();
        expect_line("R6 second in order", 5);
        tick();
        expect_line("R6 third in order", 7);
        tick();
        expect_idle("R6 drained");
        lvl = '0;
        tick();
        expect_idle("R3 multi fall");
    endtask

    task automatic t_merge();
        ready = 0;
        lvl = 8'h40;
        tick();
        expect_line("R7 first edge", 6);
        lvl = '0;
        tick();
        expect_line("R8 still waiting after fall", 6);
        lvl = 8'h40;
        tick();
        expect_line("R7 second edge merged", 6);
        tick();
        expect_line("R8 stall hold", 6);
        ready = 1;
        tick();
        expect_idle("R7 only one request after merge");
        lvl = '0;
        tick();
        expect_idle("R10 history tracked while waiting");
    endtask

    task automatic t_preempt();
        ready = 0;
        lvl = 8'h80;
        tick();
        expect_line("R6 watchdog 3 waiting", 7);
        lvl = 8'h81;
        tick();
        expect_line("R6 lower line rises while waiting", 0);
        ready = 1;
        tick();
        expect_line("R6 higher line after lower", 7);
        tick();
        expect_idle("R6 both served");
        lvl = '0;
        tick();
    endtask

    initial begin
        t_reset();
        t_each_line();
        t_multi();
        t_merge();
        t_preempt();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule